// File: doc/BRIEF.md
# Nibble-Lane CRC-32 Frame Integrity Checker

This block watches a stream of 16-bit pixel words and confirms that every displayed frame matches a reference frame bit for bit. The word is split into four 4-bit lanes. Lanes 0 to 2 hold the three colour channels and lane 3 holds a test pattern that is never shown. Each lane feeds its own CRC-32 engine. The engine uses polynomial 0x04C11DB7 and starts from 0xFFFFFFFF. It takes the four lane bits most significant bit first and applies no final XOR.

The block has two modes. In capture mode, a frame is streamed through the block while it is being copied into memory, and the four CRCs of that frame become the reference values. In check mode, the block recomputes the four CRCs over each displayed frame at the pixel rate. At the end of the frame it compares each CRC with its reference. Each lane has an error output that shows the result for the most recent checked frame. A sticky fail flag records that any lane ever mismatched. The memory and the display pipeline are outside this block.

Top module: `nibcrc_frame_checker`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `lane_err` is 0000 and `frame_fail` is 0.
- R2: A word enters the CRCs only in cycles where `pix_valid` is 1. Data presented while `pix_valid` is 0 has no effect on any result.
- R3: A cycle with `frame_start` at 1 reloads each lane CRC to 0xFFFFFFFF before that cycle's word is taken. Valid words that arrive between one frame's end and the next `frame_start` do not affect the next frame.
- R4: In capture mode (`capture_mode`=1), the final CRCs are stored as references on the clock edge where `frame_end` is 1. `lane_err` and `frame_fail` do not change on a capture frame.
- R5: In check mode (`capture_mode`=0), if the frame ending with `frame_end` carries the same valid words as the captured frame, all `lane_err` bits are 0 in the cycle after that edge.
- R6: Lane i consists of bits [4i+3:4i] of `pix_data`. A change of any nibble in lane i sets `lane_err[i]` alone after the end of a check frame.
- R7: `lane_err` changes only at the end of a check frame, where it takes that frame's per-lane mismatch result. It holds through the whole of the next frame, so a lane that fails on some frames and not others goes on and off.
- R8: `frame_fail` becomes 1 on the first check-frame mismatch in any lane. It stays at 1 until `rst`, and it is never 1 while no lane has mismatched since reset.
- R9: The references change only at the end of a capture frame. Check frames leave them untouched.
- R10: A frame of one word, with `frame_start` and `frame_end` in the same cycle, is captured and checked like any other frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_data | input | 16 | Pixel word; lane i is bits [4i+3:4i] |
| pix_valid | input | 1 | Word in `pix_data` is part of the frame |
| frame_start | input | 1 | First cycle of a frame; reloads the CRCs |
| frame_end | input | 1 | Last cycle of a frame; triggers capture or compare |
| capture_mode | input | 1 | 1 = capture references, 0 = check against references |
| lane_err | output | 4 | Per-lane mismatch result of the latest check frame |
| frame_fail | output | 1 | Sticky: some lane has mismatched since reset |

## Verification
The bench alternates clean and corrupted check frames. This catches a design that clears the error bits every frame but never sets them again, or that lets a past error linger. It corrupts one nibble in chosen lanes, which exposes a swapped or shifted lane mapping. It also samples the error bits in the middle of a frame, which catches a design that updates them early. The bench places garbage on invalid cycles and valid junk words before a frame start, so a design that ignores `pix_valid` or skips the reload would report false mismatches. It re-captures a different frame after an error to show that capture neither clears `lane_err` nor is blocked, and it checks the old frame against the new reference to show that check frames do not overwrite references. Single-word frames cover the case where reload and compare fall in the same cycle.

// File: rtl/nibcrc_pkg.sv
package nibcrc_pkg;

    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef logic [CRC_W-1:0] crc_t;

    typedef enum logic {
        MODE_CHECK   = 1'b0,
        MODE_CAPTURE = 1'b1
    } run_mode_e;

    // Decoded per-cycle frame control shared by all lanes
    typedef struct packed {
        logic      take;   // word enters the CRC this cycle
        logic      open;   // reload seed before this word
        logic      close;  // frame finishes this cycle
        run_mode_e mode;
    } frame_ctl_t;

    // One serial CRC step, data bit shifted in at the top
    function automatic crc_t crc_shift_bit(crc_t cur, logic din);
        logic fb;
        fb = cur[CRC_W-1] ^ din;
        return {cur[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/nibcrc_frame_ctl.sv
module nibcrc_frame_ctl
    import nibcrc_pkg::*;
(
    input  logic       pix_valid,
    input  logic       frame_start,
    input  logic       frame_end,
    input  logic       capture_mode,
    output frame_ctl_t ctl
);
    always_comb begin
        ctl.take  = pix_valid;
        ctl.open  = frame_start;
        ctl.close = frame_end;
        ctl.mode  = capture_mode ? MODE_CAPTURE : MODE_CHECK;
    end
endmodule

// File: rtl/nibcrc_lane_engine.sv
module nibcrc_lane_engine
    import nibcrc_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  frame_ctl_t       ctl,
    input  logic [NIB_W-1:0] nib,
    output crc_t             crc_final
);
    crc_t run_q;
    crc_t base;
    crc_t nxt;

    always_comb begin
        base = ctl.open ? CRC_SEED : run_q;
        nxt  = base;
        if (ctl.take) begin
            for (int b = NIB_W - 1; b >= 0; b--) begin
                nxt = crc_shift_bit(nxt, nib[b]);
            end
        end
    end

    assign crc_final = nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= CRC_SEED;
        end else if (ctl.close) begin
            run_q <= CRC_SEED;
        end else begin
            run_q <= nxt;
        end
    end
endmodule

// File: rtl/nibcrc_lane_judge.sv
module nibcrc_lane_judge
    import nibcrc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  frame_ctl_t ctl,
    input  crc_t       crc_final,
    output crc_t       ref_q,
    output logic       err_q,
    output logic       miss_now
);
    logic do_capture;
    logic do_check;

    assign do_capture = ctl.close && (ctl.mode == MODE_CAPTURE);
    assign do_check   = ctl.close && (ctl.mode == MODE_CHECK);
    assign miss_now   = do_check && (crc_final != ref_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (do_capture) ref_q <= crc_final;
            if (do_check)   err_q <= miss_now;
        end
    end
endmodule

// File: rtl/nibcrc_frame_checker.sv
module nibcrc_frame_checker
    import nibcrc_pkg::*;
#(
    parameter int LANES = 4,
    parameter int NIB_W = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LANES*NIB_W-1:0] pix_data,
    input  logic                   pix_valid,
    input  logic                   frame_start,
    input  logic                   frame_end,
    input  logic                   capture_mode,
    output logic [LANES-1:0]       lane_err,
    output logic                   frame_fail
);
    localparam int REF_W = LANES * CRC_W;

    frame_ctl_t       ctl;
    logic [LANES-1:0] miss_vec;
    logic [REF_W-1:0] ref_bus;
    logic             fail_q;

    nibcrc_frame_ctl u_ctl (
        .pix_valid    (pix_valid),
        .frame_start  (frame_start),
        .frame_end    (frame_end),
        .capture_mode (capture_mode),
        .ctl          (ctl)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        crc_t lane_crc;
        crc_t lane_ref;

        nibcrc_lane_engine #(.NIB_W(NIB_W)) u_eng (
            .clk       (clk),
            .rst       (rst),
            .ctl       (ctl),
            .nib       (pix_data[g*NIB_W +: NIB_W]),
            .crc_final (lane_crc)
        );

        nibcrc_lane_judge u_judge (
            .clk       (clk),
            .rst       (rst),
            .ctl       (ctl),
            .crc_final (lane_crc),
            .ref_q     (lane_ref),
            .err_q     (lane_err[g]),
            .miss_now  (miss_vec[g])
        );

        assign ref_bus[g*CRC_W +: CRC_W] = lane_ref;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fail_q <= 1'b0;
        end else if (|miss_vec) begin
            fail_q <= 1'b1;
        end
    end

    assign frame_fail = fail_q;
endmodule

// File: rtl/nibcrc_frame_checker_sva.sv
module nibcrc_frame_checker_sva #(
    parameter int LANES = 4,
    parameter int REF_W = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             frame_end,
    input logic             capture_mode,
    input logic [LANES-1:0] lane_err,
    input logic             frame_fail,
    input logic [REF_W-1:0] ref_bus
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (lane_err == '0) && !frame_fail);  // R1

    AST_ERR_ONLY_AT_CHECK_END: assert property (@(posedge clk) disable iff (rst)
        !(frame_end && !capture_mode) |=> $stable(lane_err));  // R7

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        frame_fail |=> frame_fail);  // R8

    AST_FAIL_RISES_WITH_ERR: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_fail) |-> (lane_err != '0));  // R8

    AST_ERR_IMPLIES_FAIL: assert property (@(posedge clk) disable iff (rst)
        (lane_err != '0) |-> frame_fail);  // R8

    AST_REF_ONLY_AT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        !(frame_end && capture_mode) |=> $stable(ref_bus));  // R9
endmodule

bind nibcrc_frame_checker nibcrc_frame_checker_sva #(
    .LANES (LANES),
    .REF_W (REF_W)
) u_sva (
    .clk          (clk),
    .rst          (rst),
    .frame_end    (frame_end),
    .capture_mode (capture_mode),
    .lane_err     (lane_err),
    .frame_fail   (frame_fail),
    .ref_bus      (ref_bus)
);

// File: tb/nibcrc_frame_checker_tb.sv
module nibcrc_frame_checker_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] pix_data = '0;
    logic        pix_valid = 1'b0;
    logic        frame_start = 1'b0;
    logic        frame_end = 1'b0;
    logic        capture_mode = 1'b0;
    logic [3:0]  lane_err;
    logic        frame_fail;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;  // 125 MHz

    nibcrc_frame_checker u_dut (
        .clk          (clk),
        .rst          (rst),
        .pix_data     (pix_data),
        .pix_valid    (pix_valid),
        .frame_start  (frame_start),
        .frame_end    (frame_end),
        .capture_mode (capture_mode),
        .lane_err     (lane_err),
        .frame_fail   (frame_fail)
    );

    // {capture, pattern[3:0], corrupt_mask[3:0], exp_err[3:0], exp_fail}
    localparam int NV = 11;
    localparam logic [13:0] VEC [NV] = '{
        {1'b1, 4'd1, 4'b0000, 4'b0000, 1'b0},  // R4 capture
        {1'b0, 4'd1, 4'b0000, 4'b0000, 1'b0},  // R5 clean
        {1'b0, 4'd1, 4'b0010, 4'b0010, 1'b1},  // R6 lane 1
        {1'b0, 4'd1, 4'b0000, 4'b0000, 1'b1},  // R7 flicker off, R8 sticky
        {1'b0, 4'd1, 4'b1001, 4'b1001, 1'b1},  // R6 lanes 0,3
        {1'b0, 4'd1, 4'b1111, 4'b1111, 1'b1},  // R6 all
        {1'b1, 4'd2, 4'b0000, 4'b1111, 1'b1},  // R4 capture holds err
        {1'b0, 4'd2, 4'b0000, 4'b0000, 1'b1},  // R5 new reference
        {1'b0, 4'd1, 4'b0000, 4'b1111, 1'b1},  // R9 old frame now fails
        {1'b0, 4'd2, 4'b0100, 4'b0100, 1'b1},  // R6 lane 2
        {1'b0, 4'd2, 4'b1000, 4'b1000, 1'b1}   // R6 lane 3
    };

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pat_word(input int pat, input int k);
        logic [15:0] w;
        for (int j = 0; j < 4; j++) w[j*4 +: 4] = 4'((pat*3 + k*5 + j*7) & 15);
        return w;
    endfunction

    function automatic logic [15:0] lane_flip(input logic [3:0] mask);
        logic [15:0] f;
        for (int j = 0; j < 4; j++) f[j*4 +: 4] = mask[j] ? 4'h5 : 4'h0;
        return f;
    endfunction

    // 8 valid words with invalid garbage cycles; err sampled mid-frame
    task automatic send_frame(input logic cap, input int pat, input logic [3:0] mask,
                              input int junk, input bit pre_junk, input logic [3:0] hold_exp,
                              input string tag);
        if (pre_junk) begin
            for (int p = 0; p < 3; p++) begin
                @(negedge clk);
                pix_valid = 1'b1; pix_data = 16'hA5C3 ^ 16'(p*977);
                frame_start = 1'b0; frame_end = 1'b0;
            end
        end
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (k == 4) chk({tag, " R7 mid-frame hold"}, lane_err, hold_exp);
            capture_mode = cap;
            pix_valid    = 1'b1;
            pix_data     = pat_word(pat, k) ^ ((k == 3) ? lane_flip(mask) : 16'h0);
            frame_start  = (k == 0);
            frame_end    = (k == 7);
            if (k % 2 == 1 && k != 7) begin
                @(negedge clk);
                pix_valid = 1'b0; frame_start = 1'b0; frame_end = 1'b0;
                pix_data  = 16'(junk * 4099 + k * 31);
            end
        end
        @(negedge clk);
        pix_valid = 1'b0; frame_start = 1'b0; frame_end = 1'b0; pix_data = 16'hFFFF;
    endtask

    task automatic send_single(input logic cap, input logic [15:0] w);
        @(negedge clk);
        capture_mode = cap; pix_valid = 1'b1; pix_data = w;
        frame_start = 1'b1; frame_end = 1'b1;
        @(negedge clk);
        pix_valid = 1'b0; frame_start = 1'b0; frame_end = 1'b0; pix_data = 16'h0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [3:0] prev;
        repeat (3) @(negedge clk);
        chk("R1 err during reset", lane_err, 4'b0000);
        chk("R1 fail during reset", {3'b0, frame_fail}, 4'b0000);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 err after reset", lane_err, 4'b0000);

        prev = 4'b0000;
        for (int v = 0; v < NV; v++) begin
            send_frame(VEC[v][13], int'(VEC[v][12:9]), VEC[v][8:5], v, 1'b0, prev,
                       $sformatf("vec%0d", v));
            chk($sformatf("vec%0d R5/R6 lane_err", v), lane_err, VEC[v][4:1]);
            chk($sformatf("vec%0d R8 frame_fail", v), {3'b0, frame_fail}, {3'b0, VEC[v][0]});
            prev = VEC[v][4:1];
        end

        // R1: reset clears sticky state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1 err after mid-run reset", lane_err, 4'b0000);
        chk("R1 fail after mid-run reset", {3'b0, frame_fail}, 4'b0000);

        // R3: valid junk words before frame_start are discarded
        send_frame(1'b1, 3, 4'b0000, 7, 1'b0, 4'b0000, "cap3");
        send_frame(1'b0, 3, 4'b0000, 7, 1'b1, 4'b0000, "r3");
        chk("R3 pre-start junk ignored", lane_err, 4'b0000);

        // R2: different garbage on invalid cycles gives no mismatch
        send_frame(1'b0, 3, 4'b0000, 12345, 1'b0, 4'b0000, "r2");
        chk("R2 invalid data ignored", lane_err, 4'b0000);
        chk("R2 fail still clear", {3'b0, frame_fail}, 4'b0000);

        // R10: single-word frames
        send_single(1'b1, 16'h1234);
        send_single(1'b0, 16'h1234);
        chk("R10 single-word match", lane_err, 4'b0000);
        send_single(1'b0, 16'h1F34);
        chk("R10 single-word lane 2 mismatch", lane_err, 4'b0100);
        chk("R8 fail after single-word mismatch", {3'b0, frame_fail}, 4'b0001);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule